// File: doc/BRIEF.md
# Byte Access Bridge over Word-Only Memory

This block lets a 16-bit datapath issue byte and word loads and stores to an external memory that can only be addressed by whole words and has no byte enables. The request side presents a byte address, write data, a direction and a size flag with a one-cycle valid strobe. The block reports busy and a one-cycle done pulse. The memory side carries a word address, separate read and write strobes, write data, read data and a ready handshake.

Word loads and word stores go straight through as a single memory phase. A byte load reads the containing word once and returns the addressed byte, zero-extended. A byte store reads the containing word, replaces the addressed byte lane with the new byte, and writes the whole word back to the same word address. The other lane keeps exactly the value that was read.

The lowest byte-address bit only selects the lane and never reaches memory. Every memory phase holds its strobe until ready is seen, so any memory latency is absorbed. A request is taken only while the block is idle.

Top module: `bytemem_bridge`

## Requirements
- R1: The word address presented to memory is the request byte address with bit 0 removed (byte address 2n and 2n+1 both give word n), and it stays constant for as long as a strobe waits for ready.
- R2: A byte load (req_write=0, req_byte=1) performs exactly one memory read and no write. At done, req_rdata holds the addressed byte zero-extended: address bit 0 = 0 gives read bits 7:0, and address bit 0 = 1 gives read bits 15:8.
- R3: A byte store (req_write=1, req_byte=1) performs one read, then one write to the same word address. The written word carries req_wdata[7:0] in the addressed lane (bit 0 = 0 gives lane 7:0, bit 0 = 1 gives lane 15:8). req_wdata[15:8] is not used.
- R4: During a byte store, the lane that is not addressed is written back bit-for-bit as it was read.
- R5: A word load (req_write=0, req_byte=0) performs one read and no write. At done, req_rdata holds the full read word.
- R6: A word store (req_write=1, req_byte=0) performs one write of the full req_wdata and no read.
- R7: Each memory phase holds its strobe until mem_ready is sampled high, and mem_rd and mem_wr are never high together. A phase that meets L wait cycles lasts L+1 cycles. Busy therefore lasts L+2 cycles for a single-phase operation and 2L+3 cycles for a byte store.
- R8: req_busy rises in the cycle after a request is accepted and stays high through the done cycle. A req_valid seen while busy is ignored: it causes no memory access and no later operation.
- R9: req_done is high for exactly one cycle per operation, and req_busy is low in the following cycle.
- R10: While reset is asserted (rst_n low), req_busy, req_done, mem_rd and mem_wr are 0 and req_rdata is zero.
- R11: req_rdata is zero except in the done cycle of a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | WORD_W | Store data; byte store uses bits 7:0 |
| req_busy | output | 1 | Operation in progress |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | WORD_W | Load result, valid with req_done |
| mem_addr | output | ADDR_W-1 | Word address to memory |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | WORD_W | Word written to memory |
| mem_rdata | input | WORD_W | Word read from memory |
| mem_ready | input | 1 | Memory phase complete |

## Verification
A wrong lane register shows up in the first write phase of a byte store as a corrupted neighbour byte in memory, or at the done cycle of a byte load as the wrong byte. A sequencer state that skips or repeats a phase changes the number of memory reads and writes. It also moves the done pulse away from the L+2 or 2L+3 cycles predicted for the injected wait count, so it is visible within one operation. A lost hold on a strobe or address while ready is low is caught by the memory model as a wrong word address in that same phase.

// File: rtl/bmb_pkg.sv
package bmb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_DONE  = 2'd3
   } bmb_state_e;

   typedef struct packed {
      logic write;
      logic is_byte;
   } bmb_op_t;

endpackage

// File: rtl/bmb_lane_extract.sv
module bmb_lane_extract #(
   parameter int WORD_W = 16,
   parameter int LANES  = WORD_W / 8,
   parameter int LSEL_W = $clog2(LANES)
) (
   input  logic [WORD_W-1:0] word_in,
   input  logic [LSEL_W-1:0] lane_sel,
   output logic [WORD_W-1:0] byte_zext
);

   logic [7:0] picked;

   generate
      if (LANES == 2) begin : g_pair
         assign picked = lane_sel[0] ? word_in[15:8] : word_in[7:0];
      end else begin : g_wide
         logic [7:0] lane_b [LANES];
         for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign lane_b[i] = word_in[8*i +: 8];
         end
         assign picked = lane_b[lane_sel];
      end
   endgenerate

   assign byte_zext = {{(WORD_W-8){1'b0}}, picked};

endmodule

// File: rtl/bmb_lane_merge.sv
module bmb_lane_merge #(
   parameter int WORD_W = 16,
   parameter int LANES  = WORD_W / 8,
   parameter int LSEL_W = $clog2(LANES)
) (
   input  logic [WORD_W-1:0] old_word,
   input  logic [7:0]        new_byte,
   input  logic [LSEL_W-1:0] lane_sel,
   output logic [WORD_W-1:0] merged
);

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign merged[8*i +: 8] = (lane_sel == LSEL_W'(i)) ? new_byte
                                                            : old_word[8*i +: 8];
      end
   endgenerate

endmodule

// File: rtl/bmb_ctrl.sv
module bmb_ctrl
   import bmb_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int WA_W   = 15,
   parameter int LSEL_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_byte,
   input  logic [WA_W-1:0]   req_waddr,
   input  logic [LSEL_W-1:0] req_lane,
   input  logic [WORD_W-1:0] req_wdata,
   input  logic              mem_ready,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [WA_W-1:0]   mem_addr,
   output bmb_op_t           op_q,
   output logic [LSEL_W-1:0] lane_q,
   output logic [WORD_W-1:0] wdata_q,
   output logic [WORD_W-1:0] rd_word_q
);

   bmb_state_e state_q, state_d;
   logic       accept;

   assign accept = (state_q == ST_IDLE) && req_valid;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (req_valid)
                      state_d = (req_write && !req_byte) ? ST_WRITE : ST_READ;
         ST_READ:  if (mem_ready)
                      state_d = op_q.write ? ST_WRITE : ST_DONE;
         ST_WRITE: if (mem_ready)
                      state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q     <= '0;
         lane_q   <= '0;
         wdata_q  <= '0;
         mem_addr <= '0;
      end else if (accept) begin
         op_q.write   <= req_write;
         op_q.is_byte <= req_byte;
         lane_q       <= req_lane;
         wdata_q      <= req_wdata;
         mem_addr     <= req_waddr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_word_q <= '0;
      end else if ((state_q == ST_READ) && mem_ready) begin
         rd_word_q <= mem_rdata;
      end
   end

   assign busy   = (state_q != ST_IDLE);
   assign done   = (state_q == ST_DONE);
   assign mem_rd = (state_q == ST_READ);
   assign mem_wr = (state_q == ST_WRITE);

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)) else $error("read and write strobes together"); // R7
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_ready) |=> mem_rd) else $error("read strobe dropped early"); // R7
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !mem_ready) |=> mem_wr) else $error("write strobe dropped early"); // R7
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && !mem_ready) |=> $stable(mem_addr)) else $error("address moved"); // R1
   AST_RMW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(mem_wr) && op_q.is_byte) |-> $past(mem_rd && mem_ready)) else $error("byte write without read"); // R3
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R9
   AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy) else $error("done without busy"); // R8

endmodule

// File: rtl/bytemem_bridge.sv
module bytemem_bridge
   import bmb_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int WORD_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic                       req_write,
   input  logic                       req_byte,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [WORD_W-1:0]          req_wdata,
   output logic                       req_busy,
   output logic                       req_done,
   output logic [WORD_W-1:0]          req_rdata,
   output logic [ADDR_W-$clog2(WORD_W/8)-1:0] mem_addr,
   output logic                       mem_rd,
   output logic                       mem_wr,
   output logic [WORD_W-1:0]          mem_wdata,
   input  logic [WORD_W-1:0]          mem_rdata,
   input  logic                       mem_ready
);

   localparam int LANES  = WORD_W / 8;
   localparam int LSEL_W = $clog2(LANES);
   localparam int WA_W   = ADDR_W - LSEL_W;

   initial begin
      if ((WORD_W % 8) != 0 || WORD_W < 16)
         $fatal(1, "WORD_W must be a multiple of 8 and at least 16");
      if ((LANES & (LANES - 1)) != 0)
         $fatal(1, "lane count must be a power of two");
      if (ADDR_W <= LSEL_W)
         $fatal(1, "ADDR_W too small for lane select");
   end

   bmb_op_t           op_q;
   logic [LSEL_W-1:0] lane_q;
   logic [WORD_W-1:0] wdata_q;
   logic [WORD_W-1:0] rd_word_q;
   logic [WORD_W-1:0] byte_zext;
   logic [WORD_W-1:0] merged;

   bmb_ctrl #(
      .WORD_W (WORD_W),
      .WA_W   (WA_W),
      .LSEL_W (LSEL_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_byte  (req_byte),
      .req_waddr (req_addr[ADDR_W-1:LSEL_W]),
      .req_lane  (req_addr[LSEL_W-1:0]),
      .req_wdata (req_wdata),
      .mem_ready (mem_ready),
      .mem_rdata (mem_rdata),
      .busy      (req_busy),
      .done      (req_done),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_addr  (mem_addr),
      .op_q      (op_q),
      .lane_q    (lane_q),
      .wdata_q   (wdata_q),
      .rd_word_q (rd_word_q)
   );

   bmb_lane_extract #(
      .WORD_W (WORD_W)
   ) u_extract (
      .word_in   (rd_word_q),
      .lane_sel  (lane_q),
      .byte_zext (byte_zext)
   );

   bmb_lane_merge #(
      .WORD_W (WORD_W)
   ) u_merge (
      .old_word (rd_word_q),
      .new_byte (wdata_q[7:0]),
      .lane_sel (lane_q),
      .merged   (merged)
   );

   assign mem_wdata = op_q.is_byte ? merged : wdata_q;

   assign req_rdata = (req_done && !op_q.write)
                      ? (op_q.is_byte ? byte_zext : rd_word_q)
                      : '0;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
         AST_KEEP_LANE: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_wr && op_q.is_byte && lane_q != LSEL_W'(i))
               |-> mem_wdata[8*i +: 8] == rd_word_q[8*i +: 8])
            else $error("neighbour lane altered"); // R4
         AST_NEW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_wr && op_q.is_byte && lane_q == LSEL_W'(i))
               |-> mem_wdata[8*i +: 8] == wdata_q[7:0])
            else $error("addressed lane not replaced"); // R3
      end
   endgenerate

   AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_done |-> req_rdata == '0) else $error("rdata outside done"); // R11

endmodule

// File: tb/bytemem_bridge_bench.sv
module bytemem_bridge_bench;

   localparam int ADDR_W = 16;
   localparam int WORD_W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic        req_byte = 1'b0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_busy, req_done;
   logic [15:0] req_rdata;
   logic [14:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata;
   logic        mem_ready = 1'b0;

   logic [15:0] mem [0:15];
   int          latency = 0;
   int          wcnt = 0;
   int          rd_hs = 0;
   int          wr_hs = 0;
   int          rd_at_wr = 0;
   int          addr_err = 0;
   logic [14:0] exp_waddr = '0;
   int          checks = 0;
   int          errors = 0;
   bit          finished = 0;

   always #4 clk = ~clk;

   bytemem_bridge #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_bytemem_bridge (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_busy(req_busy), .req_done(req_done), .req_rdata(req_rdata),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   assign mem_rdata = mem[mem_addr[3:0]];

   always @(posedge clk) begin
      if (mem_ready && (mem_rd || mem_wr)) begin
         if (mem_wr) begin
            mem[mem_addr[3:0]] <= mem_wdata;
            wr_hs    <= wr_hs + 1;
            rd_at_wr <= rd_hs;
         end
         if (mem_rd) rd_hs <= rd_hs + 1;
         wcnt <= 0;
      end else if (mem_rd || mem_wr) begin
         wcnt <= wcnt + 1;
      end
   end

   always @(negedge clk) begin
      mem_ready <= (mem_rd || mem_wr) && (wcnt >= latency);
      if ((mem_rd || mem_wr) && mem_addr !== exp_waddr) addr_err <= addr_err + 1;
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic wr, input logic by, input logic [15:0] addr,
                         input logic [15:0] wd, input int lat,
                         output logic [15:0] rd, output int busy_cyc);
      int dn;
      latency   = lat;
      exp_waddr = addr[15:1];
      rd = '0; busy_cyc = 0; dn = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_byte = by; req_addr = addr; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 1000; k++) begin
         if (req_busy) busy_cyc++;
         if (req_done) begin
            dn = 1; rd = req_rdata;
            break;
         end
         @(negedge clk);
      end
      chk("R9 done seen", 16'(dn), 16'd1);
      @(negedge clk);
      chk("R9 done one cycle", {15'd0, req_done}, 16'd0);
      chk("R9 idle after done", {15'd0, req_busy}, 16'd0);
      chk("R11 rdata quiet", req_rdata, 16'h0000);
   endtask

   task automatic t_reset();
      chk("R10 busy", {15'd0, req_busy}, 16'd0);
      chk("R10 done", {15'd0, req_done}, 16'd0);
      chk("R10 strobes", {14'd0, mem_rd, mem_wr}, 16'd0);
      chk("R10 rdata", req_rdata, 16'h0000);
   endtask

   task automatic t_word_store();
      logic [15:0] rd; int bc; int r0, w0;
      r0 = rd_hs; w0 = wr_hs; addr_err = 0;
      run_op(1'b1, 1'b0, 16'h0004, 16'hA1B2, 0, rd, bc);
      chk("R6 word written", mem[2], 16'hA1B2);
      chk("R6 no read", 16'(rd_hs - r0), 16'd0);
      chk("R6 one write", 16'(wr_hs - w0), 16'd1);
      chk("R7 busy cycles L0", 16'(bc), 16'd2);
      chk("R1 word address", 16'(addr_err), 16'd0);
   endtask

   task automatic t_word_load();
      logic [15:0] rd; int bc; int r0, w0;
      mem[3] = 16'h5AC3;
      r0 = rd_hs; w0 = wr_hs; addr_err = 0;
      run_op(1'b0, 1'b0, 16'h0007, 16'hFFFF, 2, rd, bc);
      chk("R5 full word", rd, 16'h5AC3);
      chk("R5 one read", 16'(rd_hs - r0), 16'd1);
      chk("R5 no write", 16'(wr_hs - w0), 16'd0);
      chk("R7 busy cycles L2", 16'(bc), 16'd4);
      chk("R1 odd address drops bit0", 16'(addr_err), 16'd0);
   endtask

   task automatic t_byte_load();
      logic [15:0] rd; int bc; int r0, w0;
      mem[6] = 16'h9E4D;
      r0 = rd_hs; w0 = wr_hs;
      run_op(1'b0, 1'b1, 16'h000C, 16'h0000, 0, rd, bc);
      chk("R2 low lane zext", rd, 16'h004D);
      run_op(1'b0, 1'b1, 16'h000D, 16'h0000, 1, rd, bc);
      chk("R2 high lane zext", rd, 16'h009E);
      chk("R2 two reads", 16'(rd_hs - r0), 16'd2);
      chk("R2 no write", 16'(wr_hs - w0), 16'd0);
      chk("R7 busy cycles L1", 16'(bc), 16'd3);
   endtask

   task automatic t_byte_store(input int lat);
      logic [15:0] rd; int bc; int r0, w0;
      mem[5] = 16'h1234;
      r0 = rd_hs; w0 = wr_hs; addr_err = 0;
      run_op(1'b1, 1'b1, 16'h000B, 16'hFFAB, lat, rd, bc);
      chk("R3 high lane replaced", mem[5][15:8], 16'h00AB);
      chk("R4 low lane kept", {8'h00, mem[5][7:0]}, 16'h0034);
      chk("R3 read then write", 16'(rd_at_wr - r0), 16'd1);
      chk("R3 one write", 16'(wr_hs - w0), 16'd1);
      chk("R7 busy cycles byte store", 16'(bc), 16'(2*lat + 3));
      chk("R11 store gives zero", rd, 16'h0000);
      run_op(1'b1, 1'b1, 16'h000A, 16'h3C77, lat, rd, bc);
      chk("R3 low lane replaced", mem[5], 16'hAB77);
      chk("R4 high lane kept", {8'h00, mem[5][15:8]}, 16'h00AB);
      chk("R1 same word both phases", 16'(addr_err), 16'd0);
   endtask

   task automatic t_ignore_busy();
      int r0, w0; logic [15:0] got;
      mem[0] = 16'h0F0F;
      mem[9] = 16'hC0DE;
      r0 = rd_hs; w0 = wr_hs; addr_err = 0; got = '0;
      latency = 4; exp_waddr = 15'd9;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_byte = 1'b1; req_addr = 16'h0013;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_byte = 1'b0; req_addr = 16'h0000;
      req_wdata = 16'hDEAD;
      @(negedge clk);
      @(negedge clk);
      chk("R8 busy while waiting", {15'd0, req_busy}, 16'd1);
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 100; k++) begin
         if (req_done) begin got = req_rdata; break; end
         @(negedge clk);
      end
      chk("R8 original op result", got, 16'h00C0);
      for (int k = 0; k < 4; k++) @(negedge clk);
      chk("R8 ignored request no write", 16'(wr_hs - w0), 16'd0);
      chk("R8 ignored request no extra read", 16'(rd_hs - r0), 16'd1);
      chk("R8 word 0 untouched", mem[0], 16'h0F0F);
      chk("R8 stays idle", {15'd0, req_busy}, 16'd0);
      chk("R1 no stray address", 16'(addr_err), 16'd0);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 16'(i * 16'h0101);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_word_store();
      t_word_load();
      t_byte_load();
      t_byte_store(0);
      t_byte_store(3);
      t_ignore_busy();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule